// File: doc/BRIEF.md
# Multiplexed Segment LCD Refresh Scanner

This block refreshes a segment LCD with eight common lines and forty segment lines from a 48-byte display area held in a RAM. The RAM is owned by a processor that writes it freely. The scanner walks the commons in a fixed rotation. At the start of each common's time slot it reads that common's display bytes through a synchronous read port. It then presents the common select and the forty segment values together, and holds them for the rest of the slot.

Each common owns a group of six consecutive bytes, which gives forty-eight bit positions. Only forty segment pins exist, so the scanner reads the first five bytes of a group and never touches the last one. A full refresh of all eight commons takes exactly 16384 clocks. A frame-start strobe marks the entry into common 0. A polarity line flips at every frame so that the analog driver can balance the drive over time.

Top module: `lcd_ram_scanner`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, com_out, seg_out, polarity and frame_start are all zero.
- R2: Counting cycles from reset release as n, slot q = (n / 2048) mod 8. In cycles where n mod 2048 is 0 to 4, ram_rd_en is 1 and ram_addr = 6*q + (n mod 2048). In every other cycle ram_rd_en is 0. Read data is expected on ram_rdata in the cycle after the request.
- R3: While common q is driven, seg_out bit 8*k + b equals bit b of RAM byte 6*q + k, for k in 0..4 and b in 0..7. Bit 0 of a byte is the lowest-numbered segment of that byte.
- R4: com_out is one-hot with bit q set for common q. The commons follow the order 0,1,...,7,0. The outputs for slot q change in the cycle where n mod 2048 = 7 and are held for 2048 cycles.
- R5: RAM writes made after a slot's bytes have been read do not change seg_out until the next time that common is fetched.
- R6: frame_start is high for exactly one cycle, in the cycle where com_out switches to common 0. Successive pulses are 16384 cycles apart.
- R7: polarity toggles in the cycle frame_start is high and is constant otherwise. The first frame is therefore driven with polarity 1.
- R8: The sixth byte of each group (address 6*q + 5) is never read and has no effect on seg_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_rd_en | output | 1 | Display RAM read request |
| ram_addr | output | 6 | Display RAM byte address |
| ram_rdata | input | 8 | Read data, valid one cycle after the request |
| com_out | output | 8 | One-hot active common line |
| seg_out | output | 40 | Segment drive values for the active common |
| polarity | output | 1 | Frame polarity for AC balancing |
| frame_start | output | 1 | One-cycle pulse when common 0 begins |

## Verification
Read requests are checked in the same cycle they are issued, at slot offsets 0 to 4. The bench's RAM model returns data one edge later. The common, segment, polarity and frame-start outputs are due seven cycles into each slot. That delay is five request cycles, the one-cycle read latency and the transfer into the output registers. The bench's expected values therefore switch at offset 7, not earlier. At offset 6 the bench still expects the previous slot's values. The bench takes its expected segment word from its RAM model at offset 7, and RAM writes happen only well after the fetch window. Later checks therefore show whether the design's latch really holds.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int NUM_COM       = 8;
    localparam int BYTES_PER_COM = 6;
    localparam int USED_BYTES    = 5;
    localparam int BYTE_W        = 8;
    localparam int SEG_COUNT     = USED_BYTES * BYTE_W;
    localparam int DISP_BYTES    = NUM_COM * BYTES_PER_COM;
    localparam int ADDR_W        = $clog2(DISP_BYTES);
    localparam int COM_W         = $clog2(NUM_COM);
    localparam int IDX_W         = $clog2(BYTES_PER_COM);
    localparam int LOAD_SLOT     = USED_BYTES + 1;

    typedef logic [COM_W-1:0]     com_idx_t;
    typedef logic [IDX_W-1:0]     byte_idx_t;
    typedef logic [ADDR_W-1:0]    ram_addr_t;
    typedef logic [BYTE_W-1:0]    disp_byte_t;
    typedef logic [SEG_COUNT-1:0] seg_word_t;
    typedef logic [NUM_COM-1:0]   com_vec_t;

    // Per-cycle control from the slot timer
    typedef struct packed {
        logic      fetch;   // issue a read this cycle
        byte_idx_t idx;     // byte within the common's group
        logic      load;    // move the latched word to the outputs
        com_idx_t  com;     // current common
    } phase_ctl_t;

    function automatic ram_addr_t byte_addr(com_idx_t c, byte_idx_t k);
        return ram_addr_t'(int'(c) * BYTES_PER_COM + int'(k));
    endfunction

    function automatic com_vec_t com_onehot(com_idx_t c);
        return com_vec_t'(1) << c;
    endfunction

    function automatic logic is_skip_addr(ram_addr_t a);
        return (int'(a) % BYTES_PER_COM) == (BYTES_PER_COM - 1);
    endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer
    import lcd_scan_pkg::*;
#(
    parameter int PHASE_LOG2 = 11
) (
    input  logic       clk,
    input  logic       rst,
    output phase_ctl_t ctl
);

    localparam logic [PHASE_LOG2-1:0] CNT_LAST = '1;
    localparam com_idx_t              COM_LAST = com_idx_t'(NUM_COM - 1);

    logic [PHASE_LOG2-1:0] cnt_q;
    com_idx_t              com_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            com_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
                com_q <= (com_q == COM_LAST) ? '0 : com_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.fetch = cnt_q < PHASE_LOG2'(USED_BYTES);
        ctl.idx   = byte_idx_t'(cnt_q);
        ctl.load  = cnt_q == PHASE_LOG2'(LOAD_SLOT);
        ctl.com   = com_q;
    end

    // R4: the common moves on when a slot's count runs out
    assert_com_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_LAST) |=> (com_q != $past(com_q)));

endmodule

// File: rtl/lcd_byte_fetch.sv
module lcd_byte_fetch
    import lcd_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_ctl_t ctl,
    output logic       ram_rd_en,
    output ram_addr_t  ram_addr,
    input  disp_byte_t ram_rdata,
    output seg_word_t  seg_word
);

    logic       cap_q;
    byte_idx_t  cap_idx_q;
    disp_byte_t shadow_q [USED_BYTES];

    assign ram_rd_en = ctl.fetch;
    assign ram_addr  = ctl.fetch ? byte_addr(ctl.com, ctl.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q     <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_q     <= ctl.fetch;
            cap_idx_q <= ctl.idx;
        end
    end

    generate
        for (genvar i = 0; i < USED_BYTES; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    shadow_q[i] <= '0;
                end else if (cap_q && cap_idx_q == byte_idx_t'(i)) begin
                    shadow_q[i] <= ram_rdata;
                end
            end
            assign seg_word[i*BYTE_W +: BYTE_W] = shadow_q[i];
        end
    endgenerate

    // R8: the unused last byte of a group is never requested
    assert_no_skip_read_R8: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> !is_skip_addr(ram_addr));

    // R2: reads within a group step through consecutive addresses
    assert_read_order_R2: assert property (@(posedge clk) disable iff (rst)
        (ram_rd_en && ctl.idx != '0) |-> (ram_addr == $past(ram_addr) + 1'b1));

endmodule

// File: rtl/lcd_drive_reg.sv
module lcd_drive_reg
    import lcd_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_ctl_t ctl,
    input  seg_word_t  seg_word,
    output seg_word_t  seg_out,
    output com_vec_t   com_out,
    output logic       polarity,
    output logic       frame_start
);

    logic frame_edge;
    assign frame_edge = ctl.load && (ctl.com == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_out     <= '0;
            com_out     <= '0;
            polarity    <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= frame_edge;
            if (ctl.load) begin
                seg_out <= seg_word;
                com_out <= com_onehot(ctl.com);
            end
            if (frame_edge) begin
                polarity <= ~polarity;
            end
        end
    end

    assert_com_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_out));

    assert_seg_with_com_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(seg_out) |-> !$stable(com_out));

    assert_frame_on_com0_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> com_out[0]);

    assert_frame_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_pol_flip_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (polarity != $past(polarity)));

    assert_pol_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(polarity));

endmodule

// File: rtl/lcd_ram_scanner.sv
module lcd_ram_scanner
    import lcd_scan_pkg::*;
#(
    parameter int PHASE_LOG2 = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 ram_rd_en,
    output logic [ADDR_W-1:0]    ram_addr,
    input  logic [BYTE_W-1:0]    ram_rdata,
    output logic [NUM_COM-1:0]   com_out,
    output logic [SEG_COUNT-1:0] seg_out,
    output logic                 polarity,
    output logic                 frame_start
);

    phase_ctl_t ctl;
    seg_word_t  seg_word;

    lcd_phase_timer #(.PHASE_LOG2(PHASE_LOG2)) timer_i (
        .clk (clk),
        .rst (rst),
        .ctl (ctl)
    );

    lcd_byte_fetch fetch_i (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .ram_rd_en (ram_rd_en),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .seg_word  (seg_word)
    );

    lcd_drive_reg drive_i (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .seg_word    (seg_word),
        .seg_out     (seg_out),
        .com_out     (com_out),
        .polarity    (polarity),
        .frame_start (frame_start)
    );

endmodule

// File: tb/lcd_ram_scanner_tb_top.sv
module lcd_ram_scanner_tb_top;

    localparam int SLOT  = 2048;
    localparam int FRAME = 8 * SLOT;
    localparam int TOTAL = 3 * FRAME + 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ram_rd_en;
    logic [5:0]  ram_addr;
    logic [7:0]  ram_rdata = 8'h00;
    logic [7:0]  com_out;
    logic [39:0] seg_out;
    logic        polarity;
    logic        frame_start;

    logic [7:0]  mem [48];
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    lcd_ram_scanner dut_i (
        .clk         (clk),
        .rst         (rst),
        .ram_rd_en   (ram_rd_en),
        .ram_addr    (ram_addr),
        .ram_rdata   (ram_rdata),
        .com_out     (com_out),
        .seg_out     (seg_out),
        .polarity    (polarity),
        .frame_start (frame_start)
    );

    // Synchronous display RAM model, one-cycle read latency
    always @(posedge clk) begin
        if (ram_rd_en && ram_addr < 6'd48) ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R3 / R8: bytes 0..4 of group c, byte 5 left out
    function automatic logic [39:0] exp_word(input int c);
        logic [39:0] w;
        for (int k = 0; k < 5; k++) w[8*k +: 8] = mem[6*c + k];
        return w;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [39:0] e_seg;
        logic [7:0]  e_com;
        logic        e_pol;
        logic        e_fs;
        int          last_fs;
        int          ph;
        int          q;
        int          a;

        void'($urandom(32'd4242));
        for (int i = 0; i < 48; i++) begin
            mem[i] = 8'((i * 37 + 1) & 8'hFF);
            if (i % 6 == 5) mem[i] = 8'hFF;        // skip bytes: must not show (R8)
            if (i / 6 == 2) mem[i] = 8'hFF;        // directed all-ones group
            if (i / 6 == 5 && i % 6 != 5) mem[i] = 8'h00; // directed all-zero group
        end
        mem[6*1 + 0] = 8'h01;                      // walking bit positions (R3)
        mem[6*1 + 4] = 8'h80;

        e_seg = '0; e_com = '0; e_pol = 1'b0; e_fs = 1'b0; last_fs = -1;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "com_out in reset", 64'(com_out), 64'(0));
        chk("R1", "seg_out in reset", 64'(seg_out), 64'(0));
        chk("R1", "polarity in reset", 64'(polarity), 64'(0));
        chk("R1", "frame_start in reset", 64'(frame_start), 64'(0));
        rst = 1'b0;

        for (int n = 0; n < TOTAL; n++) begin
            ph = n % SLOT;
            q  = (n / SLOT) % 8;

            if (n == 0) begin
                chk("R1", "com_out after release", 64'(com_out), 64'(0));
                chk("R1", "seg_out after release", 64'(seg_out), 64'(0));
            end

            // R2: read request pattern
            if (ph < 5) begin
                chk("R2", "ram_rd_en", 64'(ram_rd_en), 64'(1));
                chk("R2", "ram_addr", 64'(ram_addr), 64'(6 * q + ph));
            end else begin
                chk("R2", "ram_rd_en idle", 64'(ram_rd_en), 64'(0));
            end

            // expected output switch at slot offset 7
            e_fs = 1'b0;
            if (ph == 7) begin
                e_com = 8'(1) << q;
                e_seg = exp_word(q);
                if (q == 0) begin
                    e_fs  = 1'b1;
                    e_pol = ~e_pol;
                    if (last_fs >= 0)
                        chk("R6", "frame period", 64'(n - last_fs), 64'(FRAME));
                    last_fs = n;
                end
            end

            chk("R4", "com_out", 64'(com_out), 64'(e_com));
            chk("R3", "seg_out", 64'(seg_out), 64'(e_seg));
            chk("R6", "frame_start", 64'(frame_start), 64'(e_fs));
            chk("R7", "polarity", 64'(polarity), 64'(e_pol));
            if (ph == 8 && n > 8)
                chk("R8", "seg_out ignores sixth byte", 64'(seg_out), 64'(exp_word(q)));
            if (ph == 1500)
                chk("R5", "seg_out held after RAM write", 64'(seg_out), 64'(e_seg));

            // stimulus, only well after the fetch window
            if (ph == 1000) begin
                for (int k = 0; k < 6; k++) mem[6*q + k] = mem[6*q + k] ^ 8'h5A;
            end
            if (ph == 1200 && n >= FRAME) begin
                for (int r = 0; r < 8; r++) begin
                    a = int'($urandom % 48);
                    mem[a] = 8'($urandom);
                end
            end

            @(negedge clk);
        end

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        summary();
        $finish;
    end

endmodule